// File: doc/BRIEF.md
# Multiplexed Bus Parity Generator and Checker

This block produces the even-parity strobe for a 32-bit address/data bus with four command/byte-enable lines. It tracks transactions from the framing, initiator-ready and target-ready strobes. For every phase that parity covers, it computes parity over the bus and presents that bit one clock later. It holds the bit until the next covered phase, so the bit stays stable until one clock after a data phase completes.

The role flag and the transaction direction choose which phases the block drives. As bus master it owns the parity line after address phases and after write data phases. As a target it owns the line only after read data phases. For every covered phase it does not own, it compares the parity received on the next clock with its own computed value. A mismatch raises a one-clock error pulse.

Top module: `pbus_parity_unit`

## Requirements
- R1: On every clock with `par_oe_o` high, the ones in the previous clock's `ad_i` and `cbe_i` plus `par_o` add up to an even number.
- R2: An address phase is a clock with `frame_i` high while no transaction is open. On the next clock, `par_o` carries the parity of that phase's bus.
- R3: In a write transaction, every data-phase clock with `irdy_i` high is a covered phase. On the next clock, `par_o` carries the parity of that clock's bus.
- R4: In a read transaction, every data-phase clock with `trdy_i` high is a covered phase. On the next clock, `par_o` carries the parity of that clock's bus.
- R5: After a clock that is not a covered phase, `par_o` keeps its previous value.
- R6: With `master_i` high at the address phase, `par_oe_o` is high on the clock after the address phase and on the clock after each covered write data phase.
- R7: With `master_i` low at the address phase, `par_oe_o` is high only on the clock after a covered read data phase. It stays low after address phases and after write data phases.
- R8: `par_oe_o` is low on any clock that does not follow a covered phase, including clocks after idle cycles.
- R9: A covered phase the block does not drive is followed one clock later by a sample of `par_i`. If that sample differs from the computed parity, `par_err_o` is high for exactly the following clock.
- R10: `par_err_o` stays low after phases the block drives, and after checked phases whose received parity matches.
- R11: While `rst` is high, and on the first clock after it, `par_o`, `par_oe_o` and `par_err_o` are 0.
- R12: `wr_i` (1 = write) and `master_i` are captured at the address phase and ignored for the rest of the transaction. A transaction ends at the data phase where `irdy_i` and `trdy_i` are both high and `frame_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ad_i | input | 32 | Address/data bus value |
| cbe_i | input | 4 | Command/byte-enable lines |
| frame_i | input | 1 | Transaction framing strobe, active high |
| irdy_i | input | 1 | Initiator ready, active high |
| trdy_i | input | 1 | Target ready, active high |
| wr_i | input | 1 | Direction: 1 = write, 0 = read; captured at the address phase |
| master_i | input | 1 | Role: 1 = bus master, 0 = target; captured at the address phase |
| par_i | input | 1 | Parity received from the bus |
| par_o | output | 1 | Computed parity bit |
| par_oe_o | output | 1 | High while this block owns the parity line |
| par_err_o | output | 1 | One-clock pulse on a received-parity mismatch |

## Verification
The assertions assume that the framing strobe is released only on a final data phase with the initiator ready asserted. They also assume every input settles before the sampling edge, so the previous clock's bus value is the one parity covers. The stimulus drops `frame_i` only together with `irdy_i` on the last planned phase. It drives all inputs half a period away from the edge. It also toggles `wr_i` and `master_i` at random inside open transactions, which checks that only the address-phase values count.

// File: rtl/pbus_par_pkg.sv
package pbus_par_pkg;

    typedef enum logic {
        TRK_IDLE = 1'b0,
        TRK_DATA = 1'b1
    } trk_state_e;

    // Per-clock classification of the bus by the tracker
    typedef struct packed {
        logic addr;   // address phase this clock
        logic qual;   // clock is covered by parity
        logic own;    // this block drives the resulting parity
    } phase_evt_t;

    // Registered parity slot presented one clock after a covered phase
    typedef struct packed {
        logic par;
        logic oe;
        logic chk;
    } par_slot_t;

    function automatic logic data_owned(input logic master, input logic wr);
        return master ? wr : !wr;
    endfunction

endpackage

// File: rtl/pbus_phase_track.sv
module pbus_phase_track
    import pbus_par_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_i,
    input  logic       irdy_i,
    input  logic       trdy_i,
    input  logic       wr_i,
    input  logic       master_i,
    output phase_evt_t evt_o
);

    trk_state_e state_q;
    logic       wr_q;
    logic       master_q;
    logic       last_done;

    assign last_done = (state_q == TRK_DATA) && irdy_i && trdy_i && !frame_i;

    always_comb begin
        evt_o = '0;
        if (state_q == TRK_IDLE) begin
            evt_o.addr = frame_i;
            evt_o.qual = frame_i;
            evt_o.own  = master_i;
        end else begin
            evt_o.qual = wr_q ? irdy_i : trdy_i;
            evt_o.own  = data_owned(master_q, wr_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= TRK_IDLE;
            wr_q     <= 1'b0;
            master_q <= 1'b0;
        end else begin
            case (state_q)
                TRK_IDLE: if (frame_i) begin
                    state_q  <= TRK_DATA;
                    wr_q     <= wr_i;
                    master_q <= master_i;
                end
                TRK_DATA: if (last_done) state_q <= TRK_IDLE;
                default:  state_q <= TRK_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pbus_par_calc.sv
module pbus_par_calc
    import pbus_par_pkg::*;
#(
    parameter int AD_W   = 32,
    parameter int BE_W   = 4,
    parameter int LANE_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_i,
    input  phase_evt_t      evt_i,
    output par_slot_t       slot_o
);

    localparam int NUM_LANES = AD_W / LANE_W;

    logic [NUM_LANES-1:0] lane_par;
    logic                 par_next;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign lane_par[g] = ^ad_i[g*LANE_W +: LANE_W];
    end

    assign par_next = (^lane_par) ^ (^cbe_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_o <= '0;
        end else if (evt_i.qual) begin
            slot_o.par <= par_next;
            slot_o.oe  <= evt_i.own;
            slot_o.chk <= !evt_i.own;
        end else begin
            slot_o.oe  <= 1'b0;
            slot_o.chk <= 1'b0;
        end
    end

endmodule

// File: rtl/pbus_par_check.sv
module pbus_par_check (
    input  logic clk,
    input  logic rst,
    input  logic chk_i,
    input  logic exp_i,
    input  logic rx_i,
    output logic err_o
);

    always_ff @(posedge clk) begin
        if (rst) err_o <= 1'b0;
        else     err_o <= chk_i && (rx_i != exp_i);
    end

    AST_ERR_AFTER_CHECK: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $past(chk_i)); // R9

endmodule

// File: rtl/pbus_parity_unit.sv
module pbus_parity_unit
    import pbus_par_pkg::*;
#(
    parameter int AD_W   = 32,
    parameter int BE_W   = 4,
    parameter int LANE_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_i,
    input  logic            frame_i,
    input  logic            irdy_i,
    input  logic            trdy_i,
    input  logic            wr_i,
    input  logic            master_i,
    input  logic            par_i,
    output logic            par_o,
    output logic            par_oe_o,
    output logic            par_err_o
);

    phase_evt_t evt;
    par_slot_t  slot;

    pbus_phase_track i_track (
        .clk      (clk),
        .rst      (rst),
        .frame_i  (frame_i),
        .irdy_i   (irdy_i),
        .trdy_i   (trdy_i),
        .wr_i     (wr_i),
        .master_i (master_i),
        .evt_o    (evt)
    );

    pbus_par_calc #(
        .AD_W   (AD_W),
        .BE_W   (BE_W),
        .LANE_W (LANE_W)
    ) i_calc (
        .clk    (clk),
        .rst    (rst),
        .ad_i   (ad_i),
        .cbe_i  (cbe_i),
        .evt_i  (evt),
        .slot_o (slot)
    );

    pbus_par_check i_check (
        .clk   (clk),
        .rst   (rst),
        .chk_i (slot.chk),
        .exp_i (slot.par),
        .rx_i  (par_i),
        .err_o (par_err_o)
    );

    assign par_o    = slot.par;
    assign par_oe_o = slot.oe;

    AST_PAR_EVEN: assert property (@(posedge clk) disable iff (rst)
        par_oe_o |-> !(^{$past(ad_i), $past(cbe_i), par_o})); // R1

    AST_PAR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(evt.qual) |-> $stable(par_o)); // R5

    AST_MASTER_ADDR_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $past(evt.addr && master_i) |-> par_oe_o); // R6

    AST_SLAVE_ADDR_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(evt.addr && !master_i) |-> !par_oe_o); // R7

    AST_OE_AFTER_QUAL: assert property (@(posedge clk) disable iff (rst)
        par_oe_o |-> $past(evt.qual)); // R8

endmodule

// File: tb/test_pbus_parity_unit.sv
`timescale 1ns/1ps
module test_pbus_parity_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe = '0;
    logic        frame = 1'b0, irdy = 1'b0, trdy = 1'b0, wr = 1'b0, master = 1'b0, par_in = 1'b0;
    logic        par_o, par_oe, par_err;

    int compared = 0;
    int mismatched = 0;
    string cur_tag = "R11";

    // behavioural reference state
    bit m_busy, m_wr, m_ms, m_par, m_oe, m_chk, m_err;
    logic [31:0] prev_ad;
    logic [3:0]  prev_cbe;

    always #2 clk = ~clk;

    pbus_parity_unit i_pbus_parity_unit (
        .clk(clk), .rst(rst), .ad_i(ad), .cbe_i(cbe), .frame_i(frame),
        .irdy_i(irdy), .trdy_i(trdy), .wr_i(wr), .master_i(master),
        .par_i(par_in), .par_o(par_o), .par_oe_o(par_oe), .par_err_o(par_err)
    );

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit q, o, ne, np;
        ne = m_chk && (par_in != m_par);
        q = 0; o = 0;
        if (rst) begin
            m_busy = 0; m_wr = 0; m_ms = 0; m_par = 0; m_oe = 0; m_chk = 0; ne = 0;
        end else begin
            if (!m_busy) begin
                if (frame) begin
                    q = 1; o = master; m_busy = 1; m_wr = wr; m_ms = master;
                end
            end else begin
                q = m_wr ? irdy : trdy;
                o = m_ms ? m_wr : !m_wr;
                if (irdy && trdy && !frame) m_busy = 0;
            end
            np = ($countones({ad, cbe}) % 2) == 1;
            if (q) begin m_par = np; m_oe = o; m_chk = !o; end
            else begin m_oe = 0; m_chk = 0; end
        end
        m_err = ne;
    endtask

    // Drive one clock of inputs at a falling edge, predict, then compare at the next falling edge
    task automatic tick(input bit fr, input bit ir, input bit tr, input bit w, input bit ms, input bit bad);
        frame = fr; irdy = ir; trdy = tr; wr = w; master = ms;
        ad = $urandom; cbe = 4'($urandom);
        par_in = bad ? !m_par : m_par;
        model_step();
        prev_ad = ad; prev_cbe = cbe;
        @(negedge clk);
        check1(cur_tag, "par_o", par_o, m_par);
        check1(cur_tag, "par_oe_o", par_oe, m_oe);
        check1(cur_tag, "par_err_o", par_err, m_err);
        if (par_oe === 1'b1)
            check1("R1", "even count", 1'(($countones({prev_ad, prev_cbe}) + int'(par_o)) % 2), 1'b0);
    endtask

    // One transaction; scr scrambles direction/role after the address phase
    task automatic txn(input bit ms, input bit w, input int nph, input bit scr, input int badpct);
        tick(1, 0, 0, w, ms, 0);
        for (int p = 0; p < nph; p++) begin
            bit last, ir, tr, done;
            last = (p == nph - 1);
            done = 0;
            while (!done) begin
                ir = last ? 1'b1 : 1'($urandom_range(0, 1));
                tr = 1'($urandom_range(0, 2) != 0);
                tick(!(last), ir, tr, scr ? 1'($urandom) : w, scr ? 1'($urandom) : ms,
                     ($urandom_range(0, 99) < badpct));
                done = ir && tr;
            end
        end
        tick(0, 0, 0, w, ms, ($urandom_range(0, 99) < badpct));
    endtask

    initial begin
        #400000;
        mismatched++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        model_step();
        repeat (3) @(negedge clk);
        cur_tag = "R11";
        check1("R11", "par_o in reset", par_o, 1'b0);
        check1("R11", "par_oe_o in reset", par_oe, 1'b0);
        check1("R11", "par_err_o in reset", par_err, 1'b0);
        rst = 0;
        tick(0, 0, 0, 0, 0, 0);

        cur_tag = "R8 idle";
        repeat (4) tick(0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 0);

        cur_tag = "R2 R3 R6 master write";
        txn(1, 1, 3, 0, 0);

        cur_tag = "R4 R9 R10 master read";
        txn(1, 0, 3, 0, 0);
        txn(1, 0, 4, 0, 100);

        cur_tag = "R7 R4 slave read";
        txn(0, 0, 3, 0, 0);

        cur_tag = "R7 R9 slave write";
        txn(0, 1, 2, 0, 100);
        txn(0, 1, 2, 0, 0);

        cur_tag = "R5 waits";
        tick(1, 0, 0, 1, 1, 0);
        repeat (3) tick(1, 0, 1, 1, 1, 0);
        tick(0, 1, 1, 1, 1, 0);
        repeat (2) tick(0, 0, 0, 0, 0, 0);

        cur_tag = "R12 latched role and direction";
        for (int i = 0; i < 40; i++) txn(1'($urandom), 1'($urandom), $urandom_range(1, 4), 1, 30);

        cur_tag = "R1 R9 R12 random";
        for (int i = 0; i < 200; i++) begin
            txn(1'($urandom), 1'($urandom), $urandom_range(1, 5), 1'($urandom), 25);
            if ($urandom_range(0, 2) == 0) tick(0, 1'($urandom), 1'($urandom), 0, 0, 1);
        end

        cur_tag = "R11 reset mid-transaction";
        tick(1, 0, 0, 1, 1, 0);
        tick(1, 1, 0, 1, 1, 0);
        rst = 1;
        tick(1, 1, 1, 1, 1, 0);
        rst = 0;
        tick(0, 0, 0, 0, 0, 0);
        txn(0, 0, 2, 0, 50);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule